// File: doc/BRIEF.md
# Sequential Lattice-Ladder IIR Filter

This block is a fixed-point IIR filter in lattice-ladder form. Its order is set by `ORDER` (16 by default). It takes one 16-bit sample at a time and returns one 16-bit result per sample. All data values and coefficients are signed two's complement with 15 fraction bits. The lattice holds `ORDER` reflection gains and `ORDER+1` state words, and the ladder holds `ORDER+1` tap weights. All three sets are held inside the block, and the state words persist from one sample to the next.

All arithmetic runs on one multiplier shared across the stages. A sample walks the lattice from the top stage down to stage zero. Each stage takes three multiply cycles, one cycle each for:
1. The forward value.
2. The upper state word.
3. The ladder tap.

One more cycle handles the bottom tap. Samples enter over a valid/ready port, and results leave over a valid/ready port. The input side is back-pressured whenever a sample is in flight or a result has not yet been taken. A held result keeps its value until the consumer raises `res_ready`. Coefficients are written one word per cycle through two plain write ports.

Top module: `lattice_ladder_iir`

## Requirements
- R1: A synchronous active-high `rst` does three things:
  - It zeroes every state word and every coefficient.
  - It abandons any sample in flight.
  - It leaves the block idle, with `smp_ready` high and `res_valid` low on the next cycle.
- R2: Sample acceptance and back-pressure work as follows:
  - A sample is taken on a rising edge where `smp_valid` and `smp_ready` are both high.
  - `smp_ready` is high only while the block is idle, and it drops on the edge that takes a sample.
  - `smp_valid` presented while `smp_ready` is low has no effect on any result.
- R3: `res_valid` first reads high in the cycle after the (3·ORDER+1)-th rising edge that follows the accepting edge.
- R4: Result hold and release work as follows:
  - While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` does not change.
  - The result is taken on an edge where both are high.
  - `smp_ready` is high in the following cycle.
- R5: Stages run from index j = ORDER-1 down to 0. Each stage first sets x = sat16(x − rnd(K[j]·s[j])).
  - rnd(p) is (p + 2^14) shifted right arithmetically by 15.
  - sat16 clips to [−32768, 32767].
  - x starts as the accepted sample.
- R6: In the same stage, after R5, s[j+1] = sat16(s[j] + rnd(K[j]·x)) is computed with the new x.
- R7: In the same stage, after R6, the full 32-bit product T[j+1]·s[j+1] is added to the ladder sum, saturating at 32 bits. The ladder sum is zero when each sample is accepted.
- R8: After stage 0, the following happens in order:
  1. s[0] takes x.
  2. T[0]·x is added to the sum with 32-bit saturation.
  3. `res_data` becomes sat16((sum + 2^14) shifted right arithmetically by 15).
- R9: State words carry over from one sample to the next, so the same input twice in a row generally gives two different results. Only R1 clears them.
- R10: Coefficient writes work as follows:
  - `k_we` writes `k_wdata` to K[`k_waddr`].
  - `t_we` writes `t_wdata` to T[`t_waddr`].
  - A write takes effect at the edge it is sampled on.
  - A K address ≥ ORDER or a T address > ORDER is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Block idle and able to take a sample |
| smp_data | input | 16 | Input sample, 1.15 |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Filter output, 1.15, rounded and clipped |
| k_we | input | 1 | Reflection gain write strobe |
| k_waddr | input | clog2(ORDER+1) | Reflection gain index |
| k_wdata | input | 16 | Reflection gain value, 1.15 |
| t_we | input | 1 | Ladder tap write strobe |
| t_waddr | input | clog2(ORDER+1) | Ladder tap index |
| t_wdata | input | 16 | Ladder tap value, 1.15 |

## Verification
The assertions assume that `rst` is the only way to abandon a sample. They also assume that coefficients are rewritten only while the block is idle, because a write during a run would change that sample's result midway. The bench writes coefficients only between handshakes and keeps `smp_valid` high across busy periods, which exercises back-pressure. It holds `res_ready` low for several cycles to exercise the hold rule. It also drives full-scale inputs and weights so that both the 16-bit and 32-bit saturation points are reached.

// File: rtl/lattice_pkg.sv
package lattice_pkg;
  // operation issued to the shared multiplier each cycle
  typedef enum logic [2:0] {
    OP_NONE,
    OP_FWD,   // forward value update
    OP_BWD,   // upper state word update
    OP_TAP,   // ladder accumulate of an upper state word
    OP_FIN    // bottom state load and bottom tap
  } op_t;
endpackage

// File: rtl/lattice_coef_bank.sv
module lattice_coef_bank #(
  parameter int ORDER = 16,
  parameter int DW    = 16,
  parameter int IW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 k_we,
  input  logic [IW-1:0]        k_waddr,
  input  logic signed [DW-1:0] k_wdata,
  input  logic                 t_we,
  input  logic [IW-1:0]        t_waddr,
  input  logic signed [DW-1:0] t_wdata,
  input  logic [IW-1:0]        k_idx,
  input  logic [IW-1:0]        t_idx,
  output logic signed [DW-1:0] k_rd,
  output logic signed [DW-1:0] t_rd
);
  logic signed [DW-1:0] k_mem [ORDER];
  logic signed [DW-1:0] t_mem [ORDER+1];

  always_ff @(posedge clk) begin
    for (int e = 0; e < ORDER; e++) begin
      if (rst) k_mem[e] <= '0;
      else if (k_we && k_waddr == IW'(e)) k_mem[e] <= k_wdata;
    end
    for (int e = 0; e <= ORDER; e++) begin
      if (rst) t_mem[e] <= '0;
      else if (t_we && t_waddr == IW'(e)) t_mem[e] <= t_wdata;
    end
  end

  always_comb begin
    k_rd = '0;
    for (int e = 0; e < ORDER; e++)
      if (k_idx == IW'(e)) k_rd = k_mem[e];
    t_rd = '0;
    for (int e = 0; e <= ORDER; e++)
      if (t_idx == IW'(e)) t_rd = t_mem[e];
  end
endmodule

// File: rtl/lattice_seq.sv
module lattice_seq
  import lattice_pkg::*;
#(
  parameter int ORDER = 16,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  output logic          smp_ready,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          start,
  output op_t           op,
  output logic [IW-1:0] k_idx,
  output logic [IW-1:0] t_idx
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN, SQ_HOLD} sq_t;

  sq_t           sq_q;
  logic [1:0]    phase_q;
  logic [IW-1:0] stage_q;

  assign smp_ready = (sq_q == SQ_IDLE);
  assign res_valid = (sq_q == SQ_HOLD);
  assign start     = smp_ready && smp_valid;
  assign k_idx     = stage_q;
  assign t_idx     = (sq_q == SQ_FIN) ? '0 : stage_q + IW'(1);

  always_comb begin
    op = OP_NONE;
    if (sq_q == SQ_RUN) begin
      case (phase_q)
        2'd0:    op = OP_FWD;
        2'd1:    op = OP_BWD;
        default: op = OP_TAP;
      endcase
    end else if (sq_q == SQ_FIN) begin
      op = OP_FIN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q    <= SQ_IDLE;
      phase_q <= '0;
      stage_q <= '0;
    end else begin
      case (sq_q)
        SQ_IDLE: if (smp_valid) begin
          sq_q    <= SQ_RUN;
          phase_q <= '0;
          stage_q <= IW'(ORDER - 1);
        end
        SQ_RUN: if (phase_q == 2'd2) begin
          phase_q <= '0;
          if (stage_q == '0) sq_q <= SQ_FIN;
          else stage_q <= stage_q - IW'(1);
        end else begin
          phase_q <= phase_q + 2'd1;
        end
        SQ_FIN:  sq_q <= SQ_HOLD;
        default: if (res_ready) sq_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lattice_datapath.sv
module lattice_datapath
  import lattice_pkg::*;
#(
  parameter int ORDER = 16,
  parameter int DW    = 16,
  parameter int FRAC  = 15,
  parameter int AW    = 32,
  parameter int IW    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [DW-1:0] smp_data,
  input  op_t                  op,
  input  logic [IW-1:0]        k_idx,
  input  logic signed [DW-1:0] k_rd,
  input  logic signed [DW-1:0] t_rd,
  output logic signed [DW-1:0] res_data
);
  localparam int PW = 2 * DW;
  localparam logic signed [AW:0] D_HI  = {{(AW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW:0] D_LO  = {{(AW-DW+2){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [AW:0] A_HI  = {2'b00, {(AW-1){1'b1}}};
  localparam logic signed [AW:0] A_LO  = {2'b11, {(AW-1){1'b0}}};
  localparam logic signed [AW:0] RND_A = (AW+1)'(2**(FRAC-1));
  localparam logic signed [PW-1:0] RND_P = PW'(2**(FRAC-1));

  function automatic logic signed [DW-1:0] clip_d(input logic signed [AW:0] v);
    if (v > D_HI) return D_HI[DW-1:0];
    if (v < D_LO) return D_LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] clip_a(input logic signed [AW:0] v);
    if (v > A_HI) return A_HI[AW-1:0];
    if (v < A_LO) return A_LO[AW-1:0];
    return v[AW-1:0];
  endfunction

  logic signed [DW-1:0] x_q;
  logic signed [DW-1:0] st_q [ORDER+1];
  logic signed [AW-1:0] acc_q;

  logic [IW-1:0]        up_idx;
  logic signed [DW-1:0] st_lo, st_up, opnd_a, opnd_b;
  logic signed [PW-1:0] prod, prod_rnd;
  logic signed [AW:0]   fwd_sum, bwd_sum, acc_sum, out_pre;

  assign up_idx = k_idx + IW'(1);

  always_comb begin
    st_lo = '0;
    st_up = '0;
    for (int e = 0; e <= ORDER; e++) begin
      if (k_idx  == IW'(e)) st_lo = st_q[e];
      if (up_idx == IW'(e)) st_up = st_q[e];
    end
  end

  // operand steering for the single shared multiplier
  always_comb begin
    opnd_a = k_rd;
    opnd_b = st_lo;
    case (op)
      OP_BWD: opnd_b = x_q;
      OP_TAP: begin opnd_a = t_rd; opnd_b = st_up; end
      OP_FIN: begin opnd_a = t_rd; opnd_b = x_q;   end
      default: ;
    endcase
  end

  assign prod     = PW'(opnd_a) * PW'(opnd_b);
  assign prod_rnd = (prod + RND_P) >>> FRAC;
  assign fwd_sum  = (AW+1)'(x_q)   - (AW+1)'(prod_rnd);
  assign bwd_sum  = (AW+1)'(st_lo) + (AW+1)'(prod_rnd);
  assign acc_sum  = (AW+1)'(acc_q) + (AW+1)'(prod);
  assign out_pre  = ((AW+1)'(acc_q) + RND_A) >>> FRAC;
  assign res_data = clip_d(out_pre);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      acc_q <= '0;
    end else if (start) begin
      x_q   <= smp_data;
      acc_q <= '0;
    end else if (op == OP_FWD) begin
      x_q <= clip_d(fwd_sum);
    end else if (op == OP_TAP || op == OP_FIN) begin
      acc_q <= clip_a(acc_sum);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e <= ORDER; e++) st_q[e] <= '0;
    end else begin
      if (op == OP_FIN) st_q[0] <= x_q;
      for (int e = 1; e <= ORDER; e++)
        if (op == OP_BWD && k_idx == IW'(e - 1)) st_q[e] <= clip_d(bwd_sum);
    end
  end
endmodule

// File: rtl/lattice_ladder_iir.sv
module lattice_ladder_iir
  import lattice_pkg::*;
#(
  parameter int ORDER = 16,
  parameter int DW    = 16,
  parameter int FRAC  = 15,
  parameter int AW    = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           smp_valid,
  output logic                           smp_ready,
  input  logic signed [DW-1:0]           smp_data,
  output logic                           res_valid,
  input  logic                           res_ready,
  output logic signed [DW-1:0]           res_data,
  input  logic                           k_we,
  input  logic [$clog2(ORDER+1)-1:0]     k_waddr,
  input  logic signed [DW-1:0]           k_wdata,
  input  logic                           t_we,
  input  logic [$clog2(ORDER+1)-1:0]     t_waddr,
  input  logic signed [DW-1:0]           t_wdata
);
  localparam int IW = $clog2(ORDER + 1);

  logic                 start;
  op_t                  op;
  logic [IW-1:0]        k_idx, t_idx;
  logic signed [DW-1:0] k_rd, t_rd;

  lattice_seq #(.ORDER(ORDER), .IW(IW)) u_seq (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .res_valid(res_valid), .res_ready(res_ready),
    .start(start), .op(op), .k_idx(k_idx), .t_idx(t_idx)
  );

  lattice_coef_bank #(.ORDER(ORDER), .DW(DW), .IW(IW)) u_coef (
    .clk(clk), .rst(rst),
    .k_we(k_we), .k_waddr(k_waddr), .k_wdata(k_wdata),
    .t_we(t_we), .t_waddr(t_waddr), .t_wdata(t_wdata),
    .k_idx(k_idx), .t_idx(t_idx), .k_rd(k_rd), .t_rd(t_rd)
  );

  lattice_datapath #(.ORDER(ORDER), .DW(DW), .FRAC(FRAC), .AW(AW), .IW(IW)) u_dp (
    .clk(clk), .rst(rst), .start(start), .smp_data(smp_data),
    .op(op), .k_idx(k_idx), .k_rd(k_rd), .t_rd(t_rd), .res_data(res_data)
  );
endmodule

// File: rtl/lattice_ladder_iir_chk.sv
module lattice_ladder_iir_chk #(
  parameter int ORDER = 16,
  parameter int DW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data
);
  localparam int LAT = 3 * ORDER + 2;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (smp_valid && smp_ready) lat_cnt <= CW'(1);
    else if (lat_cnt <= CW'(LAT)) lat_cnt <= lat_cnt + CW'(1);
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (smp_ready && !res_valid));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(smp_ready && res_valid));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_ready) |=> !smp_ready);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (lat_cnt == CW'(LAT)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> smp_ready);
endmodule

bind lattice_ladder_iir lattice_ladder_iir_chk #(.ORDER(ORDER), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/lattice_ladder_iir_test.sv
module lattice_ladder_iir_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = $clog2(N + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 smp_valid = 1'b0;
  logic                 smp_ready;
  logic signed [15:0]   smp_data = '0;
  logic                 res_valid;
  logic                 res_ready = 1'b1;
  logic signed [15:0]   res_data;
  logic                 k_we = 1'b0;
  logic [IW-1:0]        k_waddr = '0;
  logic signed [15:0]   k_wdata = '0;
  logic                 t_we = 1'b0;
  logic [IW-1:0]        t_waddr = '0;
  logic signed [15:0]   t_wdata = '0;

  lattice_ladder_iir #(.ORDER(N)) uut (
    .clk(clk), .rst(rst),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .k_we(k_we), .k_waddr(k_waddr), .k_wdata(k_wdata),
    .t_we(t_we), .t_waddr(t_waddr), .t_wdata(t_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // behavioural reference state
  longint m_k [N];
  longint m_t [N+1];
  longint m_s [N+1];
  int     m_mode = 0;   // 0 idle, 1 busy, 2 holding result
  int     m_cnt  = 0;
  longint m_res  = 0;
  bit     m_took = 0;

  function automatic longint rnd(input longint p);
    return (p + 16384) >>> 15;
  endfunction
  function automatic longint s16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic longint s32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint ref_sample(input longint xin);
    longint x, acc;
    x = xin;
    acc = 0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = N - 1 - i;
      x = s16(x - rnd(m_k[j] * m_s[j]));
      m_s[j+1] = s16(m_s[j] + rnd(m_k[j] * x));
      acc = s32(acc + m_t[j+1] * m_s[j+1]);
    end
    m_s[0] = x;
    acc = s32(acc + m_t[0] * x);
    return s16(rnd(acc));
  endfunction

  task automatic model_step();
    m_took = 0;
    if (rst) begin
      for (int e = 0; e < N; e++) m_k[e] = 0;
      for (int e = 0; e <= N; e++) begin m_t[e] = 0; m_s[e] = 0; end
      m_mode = 0;
    end else begin
      if (k_we && int'(k_waddr) < N) m_k[k_waddr] = longint'(k_wdata);
      if (t_we && int'(t_waddr) <= N) m_t[t_waddr] = longint'(t_wdata);
      case (m_mode)
        0: if (smp_valid) begin
          m_res = ref_sample(longint'(smp_data));
          m_cnt = 3 * N + 1;
          m_mode = 1;
          m_took = 1;
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) m_mode = 2;
        end
        default: if (res_ready) m_mode = 0;
      endcase
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 smp_ready", longint'(smp_ready), longint'(m_mode == 0));
    chk("R3 res_valid", longint'(res_valid), longint'(m_mode == 2));
    if (m_mode == 2) chk(cur_tag, longint'(res_data), m_res);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic put_k(input int a, input int v);
    k_we = 1'b1; k_waddr = IW'(a); k_wdata = 16'(v);
    cycle();
    k_we = 1'b0;
  endtask

  task automatic put_t(input int a, input int v);
    t_we = 1'b1; t_waddr = IW'(a); t_wdata = 16'(v);
    cycle();
    t_we = 1'b0;
  endtask

  task automatic send(input int v);
    smp_valid = 1'b1;
    smp_data  = 16'(v);
    do cycle(); while (!m_took);
    smp_valid = 1'b0;
    while (m_mode != 0) cycle();
  endtask

  task automatic clear_coefs();
    for (int e = 0; e < N; e++) put_k(e, 0);
    for (int e = 0; e <= N; e++) put_t(e, 0);
  endtask

  initial begin
    // R1: reset state and zero coefficients
    repeat (3) cycle();
    rst = 1'b0;
    cycle();
    chk("R1 ready after reset", longint'(smp_ready), 1);
    chk("R1 valid after reset", longint'(res_valid), 0);
    cur_tag = "R1";
    send(1234);

    // R8: bottom tap only, half gain
    cur_tag = "R8";
    put_t(0, 16384);
    send(1000);
    send(-32768);
    send(32767);

    // R5/R6/R7: random gains and taps
    cur_tag = "R5";
    for (int e = 0; e < N; e++) put_k(e, int'($urandom_range(24000)) - 12000);
    for (int e = 0; e <= N; e++) put_t(e, int'($urandom_range(16000)) - 8000);
    for (int n = 0; n < 8; n++) send(int'($urandom_range(40000)) - 20000);
    cur_tag = "R6";
    for (int e = 0; e < N; e++) put_k(e, int'($urandom_range(60000)) - 30000);
    for (int n = 0; n < 8; n++) send(int'($urandom_range(65535)) - 32768);

    // R9: same input twice, states carry over
    cur_tag = "R9";
    send(20000);
    send(20000);

    // R2 and R4: input held high while busy, consumer stalls
    cur_tag = "R4";
    res_ready = 1'b0;
    smp_valid = 1'b1;
    smp_data  = 16'(5000);
    do cycle(); while (!m_took);
    smp_data = 16'(-777);   // presented while busy: must not be taken yet
    while (m_mode != 2) cycle();
    repeat (6) cycle();
    res_ready = 1'b1;
    cur_tag = "R2";
    do cycle(); while (!m_took);
    smp_valid = 1'b0;
    while (m_mode != 0) cycle();

    // R7: saturation of the 32-bit sum
    cur_tag = "R7";
    clear_coefs();
    for (int e = 0; e <= N; e++) put_t(e, 32767);
    send(32767);
    send(32767);
    send(-32768);
    for (int e = 0; e < N; e++) put_k(e, -32768);
    send(32767);
    send(-32768);

    // R10: out-of-range writes are ignored
    cur_tag = "R10";
    clear_coefs();
    put_t(0, 8192);
    put_k(N, 32767);
    put_t(N + 1, 32767);
    put_t(31, -32768);
    send(16000);
    send(-16000);

    // R1: reset in the middle of a sample
    cur_tag = "R1";
    for (int e = 0; e <= N; e++) put_t(e, 3000 - 200 * e);
    for (int e = 0; e < N; e++) put_k(e, 9000 - 1000 * e);
    send(12000);
    smp_valid = 1'b1;
    smp_data  = 16'(9000);
    do cycle(); while (!m_took);
    smp_valid = 1'b0;
    repeat (10) cycle();
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    cycle();
    chk("R1 ready after mid reset", longint'(smp_ready), 1);
    for (int e = 0; e <= N; e++) put_t(e, 3000 - 200 * e);
    for (int e = 0; e < N; e++) put_k(e, 9000 - 1000 * e);
    send(12000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule